// File: doc/BRIEF.md
# LDPC Iteration and Syndrome Controller

This block sequences the iterations of a small LDPC decoder. The node arithmetic and the message memories sit outside it. When a start request arrives while the block is idle, it issues a one-cycle initialization strobe. In that pass the external datapath loads the bit-to-check messages from the channel values. The block then runs iterations. Each iteration is a check-node strobe, then a bit-node strobe, then a cycle in which the block evaluates the parity checks on the hard-decision vector that the datapath presents.

If every parity check is satisfied, decoding stops at once and reports success. If the checks still fail after the iteration cap (8 by default), the block reports failure. In both cases a one-cycle done pulse goes out. The block also reports how many iterations completed. The parity-check connectivity is a parameter, so a small test code can be set at build time.

Top module: `ldpc_iter_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it is released, all strobes, done, success and failure are low and iter_count is 0.
- R2: A start sampled high while idle causes init_stb to be high for exactly one cycle, starting in the cycle after that edge. At most one of init_stb, hstep_stb, vstep_stb and done is high in any cycle.
- R3: Each iteration takes three cycles. hstep_stb is high for one cycle, vstep_stb is high for one cycle in the next cycle, and a syndrome-check cycle follows. The first hstep_stb follows init_stb directly, and each later hstep_stb follows the check cycle of the iteration before it.
- R4: Row r of the parity-check matrix is the mask held in bits [r*N_BITS +: N_BITS] of parameter H_MATRIX, and bit j of a mask selects hard_bits[j]. The syndrome bit of a row is the XOR of the selected hard bits. The block samples hard_bits in the check cycle, which is the cycle after vstep_stb.
- R5: When every syndrome bit is zero in a check cycle, done and success are high in the next cycle. iter_count then equals the number of completed iterations.
- R6: When the syndrome is nonzero in the check cycle of iteration MAX_ITER, done and failure are high in the next cycle and iter_count equals MAX_ITER. A zero syndrome in that same check cycle gives success instead.
- R7: done lasts exactly one cycle. success and failure are never both high. Each holds its value until a start is accepted, and both are low from the cycle in which init_stb is high.
- R8: A start that arrives while a decode is running, including the done cycle, is ignored. No extra init_stb appears and the iteration sequence does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a decode, honoured only when idle |
| hard_bits | input | N_BITS | Hard-decision vector from the datapath |
| init_stb | output | 1 | One-cycle strobe for the initialization pass |
| hstep_stb | output | 1 | One-cycle strobe for the check-node step |
| vstep_stb | output | 1 | One-cycle strobe for the bit-node step |
| done | output | 1 | One-cycle pulse when the decode ends |
| success | output | 1 | Valid codeword found; held until the next accepted start |
| failure | output | 1 | Iteration cap reached without a valid codeword; held |
| iter_count | output | $clog2(MAX_ITER+1) | Number of completed iterations |

## Verification
The bench converges the hard vector on the first iteration, on middle iterations and on the last allowed iteration. A design with an off-by-one cap would report failure for last-iteration convergence, or would run a ninth iteration. A vector that never converges checks that failure appears with a count of exactly MAX_ITER and with no success. The bench issues a start in the middle of a decode and another during the done cycle. A controller that re-armed on either one would show a second init strobe or extra step strobes. The bench also checks that success stays set long after done and clears as soon as the next decode is accepted. A flag that was only pulsed, or that was never cleared, would fail that check.

// File: rtl/ldpc_ctrl_pkg.sv
package ldpc_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INIT  = 3'd1,
    ST_HSTEP = 3'd2,
    ST_VSTEP = 3'd3,
    ST_CHECK = 3'd4,
    ST_DONE  = 3'd5
  } ctrl_state_t;
endpackage

// File: rtl/ldpc_syndrome.sv
module ldpc_syndrome #(
  parameter int N_BITS   = 8,
  parameter int N_CHECKS = 4,
  parameter logic [N_CHECKS*N_BITS-1:0] H_MATRIX = '0
) (
  input  logic [N_BITS-1:0] hard_bits,
  output logic              all_clear
);
  logic [N_CHECKS-1:0] row_par;

  // one parity tree per matrix row
  for (genvar r = 0; r < N_CHECKS; r++) begin : g_row
    assign row_par[r] = ^(hard_bits & H_MATRIX[r*N_BITS +: N_BITS]);
  end

  assign all_clear = ~|row_par;
endmodule

// File: rtl/ldpc_iter_counter.sv
module ldpc_iter_counter #(
  parameter int MAX_ITER = 8,
  localparam int ITW = $clog2(MAX_ITER+1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           inc,
  output logic [ITW-1:0] count,
  output logic           on_last
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (inc && count != ITW'(MAX_ITER))
      count <= count + 1'b1;
  end

  // the iteration now in progress is the final one allowed
  assign on_last = (count == ITW'(MAX_ITER - 1));
endmodule

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl
  import ldpc_ctrl_pkg::*;
#(
  parameter int N_BITS   = 8,
  parameter int N_CHECKS = 4,
  parameter int MAX_ITER = 8,
  parameter logic [N_CHECKS*N_BITS-1:0] H_MATRIX = 32'h8B4D2E17,
  localparam int ITW = $clog2(MAX_ITER+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [N_BITS-1:0] hard_bits,
  output logic              init_stb,
  output logic              hstep_stb,
  output logic              vstep_stb,
  output logic              done,
  output logic              success,
  output logic              failure,
  output logic [ITW-1:0]    iter_count
);
  ctrl_state_t state;
  logic        syn_ok;
  logic        cnt_clr;
  logic        cnt_inc;
  logic        cnt_last;

  assign cnt_clr = (state == ST_IDLE) && start;
  assign cnt_inc = (state == ST_CHECK);

  ldpc_syndrome #(
    .N_BITS(N_BITS), .N_CHECKS(N_CHECKS), .H_MATRIX(H_MATRIX)
  ) u_syn (
    .hard_bits(hard_bits),
    .all_clear(syn_ok)
  );

  ldpc_iter_counter #(.MAX_ITER(MAX_ITER)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .count(iter_count), .on_last(cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      init_stb  <= 1'b0;
      hstep_stb <= 1'b0;
      vstep_stb <= 1'b0;
      done      <= 1'b0;
      success   <= 1'b0;
      failure   <= 1'b0;
    end else begin
      init_stb  <= 1'b0;
      hstep_stb <= 1'b0;
      vstep_stb <= 1'b0;
      done      <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_INIT;
          init_stb <= 1'b1;
          success  <= 1'b0;
          failure  <= 1'b0;
        end
        ST_INIT: begin
          state     <= ST_HSTEP;
          hstep_stb <= 1'b1;
        end
        ST_HSTEP: begin
          state     <= ST_VSTEP;
          vstep_stb <= 1'b1;
        end
        ST_VSTEP: state <= ST_CHECK;
        ST_CHECK: begin
          if (syn_ok) begin
            state   <= ST_DONE;
            done    <= 1'b1;
            success <= 1'b1;
          end else if (cnt_last) begin
            state   <= ST_DONE;
            done    <= 1'b1;
            failure <= 1'b1;
          end else begin
            state     <= ST_HSTEP;
            hstep_stb <= 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldpc_iter_ctrl_chk.sv
module ldpc_iter_ctrl_chk #(
  parameter int MAX_ITER = 8,
  parameter int ITW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           init_stb,
  input logic           hstep_stb,
  input logic           vstep_stb,
  input logic           done,
  input logic           success,
  input logic           failure,
  input logic [ITW-1:0] iter_count
);
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({init_stb, hstep_stb, vstep_stb, done}));

  a_r3_init_then_h: assert property (@(posedge clk) disable iff (rst)
    init_stb |=> hstep_stb);

  a_r3_h_then_v: assert property (@(posedge clk) disable iff (rst)
    hstep_stb |=> vstep_stb);

  a_r3_v_then_gap: assert property (@(posedge clk) disable iff (rst)
    vstep_stb |=> !(hstep_stb || done));

  a_r6_fail_at_cap: assert property (@(posedge clk) disable iff (rst)
    $rose(failure) |-> (iter_count == ITW'(MAX_ITER)));

  a_r6_count_cap: assert property (@(posedge clk) disable iff (rst)
    iter_count <= ITW'(MAX_ITER));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(success && failure));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!done && !init_stb) |-> ($stable(success) && $stable(failure)));
endmodule

bind ldpc_iter_ctrl ldpc_iter_ctrl_chk #(.MAX_ITER(MAX_ITER), .ITW(ITW)) u_chk (
  .clk(clk), .rst(rst), .init_stb(init_stb), .hstep_stb(hstep_stb),
  .vstep_stb(vstep_stb), .done(done), .success(success),
  .failure(failure), .iter_count(iter_count)
);

// File: tb/sim_ldpc_iter_ctrl.sv
module sim_ldpc_iter_ctrl;
  localparam int MAXI = 8;
  localparam int NV = 6;
  // entry: [31:24] failing vector, [23:16] passing vector,
  // [11:8] iteration whose check sees the passing vector (0 = never),
  // [4] expected success, [3:0] expected iteration count
  localparam logic [31:0] VEC [NV] = '{
    32'h0100_0111, 32'h10FF_0313, 32'h0300_0818,
    32'h0100_0008, 32'h8000_0212, 32'h77FF_0515
  };

  logic clk = 0, rst = 1, start = 0;
  logic [7:0] hard_bits = 8'h00;
  logic init_stb, hstep_stb, vstep_stb, done, success, failure;
  logic [3:0] iter_count;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ldpc_iter_ctrl u0 (
    .clk(clk), .rst(rst), .start(start), .hard_bits(hard_bits),
    .init_stb(init_stb), .hstep_stb(hstep_stb), .vstep_stb(vstep_stb),
    .done(done), .success(success), .failure(failure), .iter_count(iter_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one decode; inj > 0 pulses start on that cycle of the run
  task automatic run(input logic [31:0] v, input int inj, input bit inj_done);
    logic [7:0] bv, gv;
    int conv, ei, icnt, hcnt, vcnt, multi, order_bad, vseen;
    bit es, prev_h, got_done;
    bv = v[31:24]; gv = v[23:16]; conv = int'(v[11:8]);
    es = v[4]; ei = int'(v[3:0]);
    icnt = 0; hcnt = 0; vcnt = 0; multi = 0; order_bad = 0; vseen = 0;
    prev_h = 0; got_done = 0;
    hard_bits = bv;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(init_stb == 1, "R2 init strobe", int'(init_stb), 1);
    chk(success == 0 && failure == 0, "R7 flags cleared on start",
        int'({success, failure}), 0);
    for (int c = 0; c < 60; c++) begin
      if (int'(init_stb) + int'(hstep_stb) + int'(vstep_stb) + int'(done) > 1) multi++;
      if (init_stb) icnt++;
      if (hstep_stb) hcnt++;
      if (vstep_stb) begin
        vcnt++;
        if (!prev_h) order_bad++;
        vseen++;
        hard_bits = (conv != 0 && vseen >= conv) ? gv : bv;
      end
      prev_h = hstep_stb;
      if (done) begin got_done = 1; break; end
      if (inj != 0 && c == inj) start = 1; else start = 0;
      @(negedge clk);
    end
    start = 0;
    chk(got_done, "R5 done reached", int'(got_done), 1);
    chk(icnt == 1, "R8 single init", icnt, 1);
    chk(multi == 0, "R2 one strobe per cycle", multi, 0);
    chk(order_bad == 0, "R3 vstep after hstep", order_bad, 0);
    chk(hcnt == ei && vcnt == ei, "R3 step strobe count", hcnt, ei);
    chk(success == es, es ? "R5 success" : "R6 success low", int'(success), int'(es));
    chk(failure == !es, es ? "R5 failure low" : "R6 failure", int'(failure), int'(!es));
    chk(iter_count == 4'(ei), "R5 R6 iteration count", int'(iter_count), ei);
    if (inj_done) start = 1;
    @(negedge clk); start = 0;
    chk(done == 0, "R7 done one cycle", int'(done), 0);
    repeat (3) begin
      @(negedge clk);
      chk(init_stb == 0, "R8 start in done ignored", int'(init_stb), 0);
    end
    chk(success == es && failure == !es, "R7 flags held",
        int'({success, failure}), int'({es, !es}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({init_stb, hstep_stb, vstep_stb, done, success, failure} == 0 && iter_count == 0,
        "R1 outputs in reset", int'(iter_count), 0);
    rst = 0;
    @(negedge clk);
    chk({init_stb, hstep_stb, vstep_stb, done, success, failure} == 0 && iter_count == 0,
        "R1 outputs after reset", int'({init_stb, hstep_stb, vstep_stb, done}), 0);
    // R4 R5 R6 main table
    for (int i = 0; i < NV; i++) run(VEC[i], 0, 0);
    // R8 start mid decode, then start in the done cycle
    run(32'h0100_0414, 5, 0);
    run(32'h0100_0008, 9, 1);
    // R4 a vector valid from the start converges in one iteration
    run(32'hFF00_0111, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule